// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor with Decode Redirect

This block keeps a table of two-bit saturating counters indexed by instruction address and uses it in the decode stage. Decode presents a conditional branch together with the next-PC guess that fetch made. The block then forms its own next PC from the counter's direction. A taken prediction gives the branch target, which is the PC plus the PC-relative offset. A not-taken prediction gives the fall-through address, which is the PC plus 4. If this address differs from the fetch guess, the block sends a one-cycle redirect to fetch carrying the corrected address.

Each redirect toggles a decode-side epoch bit. Instructions that arrive afterwards still tagged with the old epoch were fetched down the wrong path. They get no lookup and cannot redirect. The execute stage trains the table by reporting the resolved outcome of each branch through a separate update port.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every counter is in the weakly-not-taken state (encoding 1), so the first lookup of any entry predicts not taken. The epoch output resets to 0.
- R2: An update with taken = 1 moves the addressed counter one step toward strongly taken (encoding 3) and holds it at 3 once there.
- R3: An update with taken = 0 moves the addressed counter one step toward strongly not-taken (encoding 0) and holds it at 0 once there. A counter predicts taken when its value is 2 or 3.
- R4: A counter in a strong state keeps its predicted direction after one opposite outcome. The direction changes only after a second opposite outcome in a row.
- R5: The table has 2^IDX_W entries. The entry is selected by PC bits [IDX_W+1:2], so two addresses that differ only in bits [1:0] or only above bit IDX_W+1 share one counter.
- R6: An instruction with the conditional-branch flag low never causes a redirect, whatever next-PC guess it carries.
- R7: The computed next PC is the PC plus the offset when the branch is predicted taken, and the PC plus 4 when it is predicted not taken.
- R8: A current-epoch branch raises the redirect when its computed next PC differs from the incoming guess, and the redirect address is the computed next PC. When the two are equal there is no redirect.
- R9: Each redirect toggles the epoch output at the next clock edge, and nothing else changes it. A decode input whose epoch tag differs from the epoch output never redirects.
- R10: When a lookup and an update address the same entry in one cycle, the lookup uses the counter value from before the update, and the update takes effect at that clock edge.
- R11: The redirect is asserted only in a cycle where decode presents a valid instruction, so it lasts a single cycle per accepted branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode presents an instruction this cycle |
| dec_pc | input | ADDR_W | Address of the instruction at decode |
| dec_is_cond | input | 1 | Instruction is a conditional branch |
| dec_offset | input | ADDR_W | PC-relative branch offset |
| dec_ppc | input | ADDR_W | Next-PC guess made by fetch |
| dec_epoch | input | 1 | Epoch tag carried by the instruction |
| upd_valid | input | 1 | Execute reports a resolved branch |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | ADDR_W | Corrected fetch address |
| epoch_o | output | 1 | Current decode-side epoch |

## Verification
Every table entry is driven through its own outcome sequence, derived from the entry number. After each training step the entry is probed twice: once with a fall-through guess and once with a target guess. The fall-through probe redirects exactly when the counter predicts taken. The target probe exposes the taken/not-taken address choice, using both forward and backward offsets.

Dedicated patterns cover the following cases:
- a strong counter hit by a single opposite outcome, which separates a two-bit counter from a one-bit one;
- aliasing addresses, which show which PC bits form the index;
- a lookup and an update on the same entry in one cycle;
- non-branch and stale-epoch instructions carrying wrong guesses;
- idle cycles directly after a redirect, which show that the redirect is a single pulse.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    typedef struct packed {
        logic active;
        logic pred_taken;
    } lookup_t;

    function automatic ctr_e ctr_next(ctr_e cur, logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_taken(ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bdp_ctr_table.sv
module bdp_ctr_table
    import bdp_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output ctr_e             rd_ctr
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_e ctr_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ctr_q[i] <= CTR_RESET;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ctr_q[i] <= ctr_next(ctr_q[i], wr_taken);
            end
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/bdp_decode_check.sv
module bdp_decode_check
    import bdp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic              dec_is_cond,
    input  logic [ADDR_W-1:0] dec_offset,
    input  logic [ADDR_W-1:0] dec_ppc,
    input  logic              dec_epoch,
    input  logic              epoch_q,
    input  ctr_e              ctr,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc
);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    lookup_t           lk;
    logic [ADDR_W-1:0] next_pc;

    always_comb begin
        lk.active     = dec_valid && dec_is_cond && (dec_epoch == epoch_q);
        lk.pred_taken = ctr_taken(ctr);
        next_pc       = lk.pred_taken ? (dec_pc + dec_offset) : (dec_pc + INSN_BYTES);
        redir_valid   = lk.active && (next_pc != dec_ppc);
        redir_pc      = next_pc;
    end

endmodule

// File: rtl/bdp_epoch_reg.sv
module bdp_epoch_reg (
    input  logic clk,
    input  logic rst,
    input  logic flip,
    output logic epoch_q
);
    always_ff @(posedge clk) begin
        if (rst)       epoch_q <= 1'b0;
        else if (flip) epoch_q <= ~epoch_q;
    end
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bdp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_pc,
    input  logic              dec_is_cond,
    input  logic [ADDR_W-1:0] dec_offset,
    input  logic [ADDR_W-1:0] dec_ppc,
    input  logic              dec_epoch,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_pc,
    output logic              epoch_o
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    ctr_e             rd_ctr;
    logic             epoch_q;
    logic             redir_int;

    assign rd_idx = dec_pc[IDX_HI:IDX_LO];
    assign wr_idx = upd_pc[IDX_HI:IDX_LO];

    bdp_ctr_table #(.IDX_W(IDX_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken),
        .rd_ctr   (rd_ctr)
    );

    bdp_decode_check #(.ADDR_W(ADDR_W)) check_i (
        .dec_valid   (dec_valid),
        .dec_pc      (dec_pc),
        .dec_is_cond (dec_is_cond),
        .dec_offset  (dec_offset),
        .dec_ppc     (dec_ppc),
        .dec_epoch   (dec_epoch),
        .epoch_q     (epoch_q),
        .ctr         (rd_ctr),
        .redir_valid (redir_int),
        .redir_pc    (redir_pc)
    );

    bdp_epoch_reg epoch_i (
        .clk     (clk),
        .rst     (rst),
        .flip    (redir_int),
        .epoch_q (epoch_q)
    );

    assign redir_valid = redir_int;
    assign epoch_o     = epoch_q;

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dec_valid,
    input logic [ADDR_W-1:0] dec_pc,
    input logic              dec_is_cond,
    input logic [ADDR_W-1:0] dec_offset,
    input logic [ADDR_W-1:0] dec_ppc,
    input logic              dec_epoch,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_pc,
    input logic              epoch_o
);
    AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dec_is_cond |-> !redir_valid); // R6
    AST_REDIR_ADDR_CHOICE: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (redir_pc == dec_pc + ADDR_W'(4)) || (redir_pc == dec_pc + dec_offset)); // R7
    AST_REDIR_DIFFERS: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> redir_pc != dec_ppc); // R8
    AST_EPOCH_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> epoch_o != $past(epoch_o)); // R9
    AST_EPOCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |=> $stable(epoch_o)); // R9
    AST_STALE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dec_epoch != epoch_o) |-> !redir_valid); // R9
    AST_REDIR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !redir_valid); // R11
endmodule

bind branch_dir_predictor bdp_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .dec_valid   (dec_valid),
    .dec_pc      (dec_pc),
    .dec_is_cond (dec_is_cond),
    .dec_offset  (dec_offset),
    .dec_ppc     (dec_ppc),
    .dec_epoch   (dec_epoch),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .epoch_o     (epoch_o)
);

// File: tb/branch_dir_predictor_tb.sv
module branch_dir_predictor_tb_top;
    localparam int AW = 32;
    localparam int KW = 4;
    localparam int NENT = 1 << KW;
    localparam logic [AW-1:0] BASE = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst;
    logic          dec_valid, dec_is_cond, dec_epoch, upd_valid, upd_taken;
    logic [AW-1:0] dec_pc, dec_offset, dec_ppc, upd_pc;
    logic          redir_valid, epoch_o;
    logic [AW-1:0] redir_pc;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  mctr [NENT];
    bit  mep;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    branch_dir_predictor #(.ADDR_W(AW), .IDX_W(KW)) dut_i (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_is_cond(dec_is_cond),
        .dec_offset(dec_offset), .dec_ppc(dec_ppc), .dec_epoch(dec_epoch),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .epoch_o(epoch_o)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int idx_of(logic [AW-1:0] pc);
        return int'((pc >> 2) & (NENT - 1));
    endfunction

    task automatic step(input bit dv, input logic [AW-1:0] pc, input bit isc,
                        input logic [AW-1:0] off, input logic [AW-1:0] ppc, input bit ep,
                        input bit uv, input logic [AW-1:0] upc, input bit ut, input string req);
        bit            exp_rv;
        logic [AW-1:0] npc;
        @(negedge clk);
        dec_valid = dv; dec_pc = pc; dec_is_cond = isc; dec_offset = off;
        dec_ppc = ppc; dec_epoch = ep;
        upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #5;
        npc    = (mctr[idx_of(pc)] >= 2) ? pc + off : pc + 32'd4;
        exp_rv = dv && isc && (ep == mep) && (npc != ppc);
        check(redir_valid == exp_rv, req, AW'(redir_valid), AW'(exp_rv));
        if (exp_rv) check(redir_pc == npc, req, redir_pc, npc);
        check(epoch_o == mep, "R9", AW'(epoch_o), AW'(mep));
        @(posedge clk);
        if (exp_rv) mep = ~mep;
        if (uv) begin
            if (ut && mctr[idx_of(upc)] < 3) mctr[idx_of(upc)]++;
            if (!ut && mctr[idx_of(upc)] > 0) mctr[idx_of(upc)]--;
        end
    endtask

    task automatic probe(input logic [AW-1:0] pc, input logic [AW-1:0] off, input logic [AW-1:0] ppc, input string req);
        step(1'b1, pc, 1'b1, off, ppc, mep, 1'b0, '0, 1'b0, req);
    endtask

    task automatic train(input logic [AW-1:0] pc, input bit t, input string req);
        step(1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, pc, t, req);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NENT; i++) mctr[i] = 1;
        mep = 1'b0;
        rst = 1'b1;
        dec_valid = 0; dec_pc = '0; dec_is_cond = 0; dec_offset = '0; dec_ppc = '0;
        dec_epoch = 0; upd_valid = 0; upd_pc = '0; upd_taken = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #5;
        check(epoch_o == 1'b0, "R1", AW'(epoch_o), '0);
        check(redir_valid == 1'b0, "R1", AW'(redir_valid), '0);

        // R1: every entry predicts not taken after reset
        for (int i = 0; i < NENT; i++) begin
            probe(BASE + AW'(i * 4), 32'h100, BASE + AW'(i * 4) + 32'd4, "R1");
            probe(BASE + AW'(i * 4), 32'h100, BASE + AW'(i * 4) + 32'h100, "R1");
        end

        // R2 R3 R7 R8: per-entry outcome sweep, fall-through and target probes
        for (int i = 0; i < NENT; i++) begin
            logic [AW-1:0] pc;
            logic [AW-1:0] off;
            int            pat;
            pc  = BASE + AW'(i * 4);
            off = (i % 2 == 1) ? -AW'(16 * (i + 1)) : AW'(32'h40 + i * 8);
            pat = (i * 37 + 5) ^ (i << 4);
            for (int s = 0; s < 10; s++) begin
                bit t;
                t = bit'((pat >> s) & 1);
                train(pc, t, t ? "R2" : "R3");
                probe(pc, off, pc + 32'd4, "R7");
                probe(pc, off, pc + off, "R8");
            end
        end

        // R2 R4: saturate taken, one not-taken keeps taken, second flips
        for (int k = 0; k < 5; k++) train(BASE + 32'h8, 1'b1, "R2");
        train(BASE + 32'h8, 1'b0, "R4");
        probe(BASE + 32'h8, 32'h20, BASE + 32'h8 + 32'h20, "R4");
        probe(BASE + 32'h8, 32'h20, BASE + 32'hC, "R4");
        train(BASE + 32'h8, 1'b0, "R4");
        probe(BASE + 32'h8, 32'h20, BASE + 32'hC, "R4");
        // R3 R4: saturate not taken, one taken keeps not taken
        for (int k = 0; k < 5; k++) train(BASE + 32'h8, 1'b0, "R3");
        train(BASE + 32'h8, 1'b1, "R4");
        probe(BASE + 32'h8, 32'h20, BASE + 32'h8 + 32'h20, "R4");
        train(BASE + 32'h8, 1'b1, "R4");
        probe(BASE + 32'h8, 32'h20, BASE + 32'hC, "R4");

        // R5: aliasing through upper bits and through byte-offset bits
        for (int k = 0; k < 3; k++) train(BASE + 32'h14, 1'b1, "R5");
        probe(BASE + 32'h14 + AW'(NENT * 4), 32'h80, BASE + 32'h14 + AW'(NENT * 4) + 32'd4, "R5");
        probe(BASE + 32'h15, 32'h80, BASE + 32'h19, "R5");
        probe(BASE + 32'h18, 32'h80, BASE + 32'h1C, "R5");

        // R6: non-branch with wrong guesses never redirects
        for (int k = 0; k < 4; k++)
            step(1'b1, BASE + 32'h14, 1'b0, 32'h80, 32'hDEAD_0000 + AW'(k), mep, 1'b0, '0, 1'b0, "R6");

        // R9: stale epoch gets no redirect and leaves epoch alone
        step(1'b1, BASE + 32'h14, 1'b1, 32'h80, 32'h0, ~mep, 1'b0, '0, 1'b0, "R9");
        step(1'b1, BASE + 32'h18, 1'b1, 32'h80, 32'h0, ~mep, 1'b0, '0, 1'b0, "R9");
        probe(BASE + 32'h18, 32'h80, 32'h0, "R9");
        step(1'b1, BASE + 32'h18, 1'b1, 32'h80, 32'h0, ~mep, 1'b0, '0, 1'b0, "R9");

        // R11: idle cycles right after a redirect stay quiet
        probe(BASE + 32'h14, 32'h80, 32'h0, "R11");
        step(1'b0, BASE + 32'h14, 1'b1, 32'h80, 32'h0, mep, 1'b0, '0, 1'b0, "R11");
        step(1'b0, BASE + 32'h14, 1'b1, 32'h80, 32'h0, mep, 1'b0, '0, 1'b0, "R11");

        // R10: same-entry lookup and update in one cycle
        for (int k = 0; k < 4; k++) train(BASE + 32'h30, 1'b0, "R10");
        train(BASE + 32'h30, 1'b1, "R10");
        step(1'b1, BASE + 32'h30, 1'b1, 32'h40, BASE + 32'h34, mep, 1'b1, BASE + 32'h30, 1'b1, "R10");
        probe(BASE + 32'h30, 32'h40, BASE + 32'h34, "R10");
        step(1'b1, BASE + 32'h30, 1'b1, 32'h40, BASE + 32'h70, mep, 1'b1, BASE + 32'h30, 1'b0, "R10");
        probe(BASE + 32'h30, 32'h40, BASE + 32'h70, "R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule